// File: doc/BRIEF.md
# TDM Time Slot Assigner

The block steers serial bits between two time-division-multiplexed links (TDM 0 and TDM 1) and a set of numbered serial channels. Each link has a receive route and a transmit route. Each route is a list of up to 16 slot descriptors held in a shared route memory. A descriptor covers a run of bits or of 8-bit bytes. For that run it names the channel that owns the data, the strobe outputs to raise, whether the slot is looped back internally, and, in receive descriptors, whether the receive and transmit pins swap roles. With the swap, two stations on the same link can talk to each other directly.

Each route advances on its own bit tick and restarts on its own frame sync, both given as single-cycle enables in the system clock domain. The memory holds two halves. The sequencer reads one half while the host fills the other, then asks for a switch. The switch takes effect on that route's next frame sync, so a frame never mixes two route versions.

Top module: `tdm_slot_assigner`

## Requirements
- R1: After reset every route is idle and in half 0. All strobes, channel codes, valid and take pulses and pin enables are low.
- R2: A descriptor word has these fields: bit 15 loopback, bit 14 pin swap, bits 13:10 strobe enables (bit n drives strobe n), bit 9 reserved (written 0), bits 8:6 channel, bits 5:2 count, bit 1 byte granularity, bit 0 last. A descriptor's memory index is {half, route, entry}: half is 1 bit, route is 2 bits (0 = RX0, 1 = RX1, 2 = TX0, 3 = TX1), entry is 4 bits.
- R3: A tick with sync set restarts the route at entry 0 of its active half. The next tick carries the first bit of the frame.
- R4: A descriptor lasts count+1 bits, or 8*(count+1) bits when its byte flag is set. The route then moves to the next entry.
- R5: After a descriptor with the last flag, or after entry 15, the route goes idle until the next sync. While idle it shows channel 0 and no strobes.
- R6: A route's strobe outputs equal its current descriptor's strobe field for every bit of the slot.
- R7: In a slot with channel 0, no valid or take pulse is given and neither pin of that link is driven.
- R8: In a receive slot with channel c not 0, each tick gives rx_valid with rx_bit equal to the receive pin, and the route's channel output reads c.
- R9: In a transmit slot with channel c not 0, the transmit pin carries tx_bit with its enable high, and each tick gives tx_take.
- R10: Loopback in a receive descriptor takes rx_bit from tx_bit. Loopback in a transmit descriptor drops both pin enables.
- R11: The swap flag in a receive descriptor takes rx_bit from the transmit pin and drives tx_bit on the receive pin, with the transmit pin enable low. The swap flag in a transmit descriptor has no effect.
- R12: A half-switch request is held until that route's next sync tick, which toggles the route's active half. bank_o shows the active half of each route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Descriptor write strobe |
| wr_idx_i | input | 7 | Descriptor index {half, route, entry} |
| wr_data_i | input | 16 | Descriptor word |
| tick_i | input | 4 | Bit tick per route (RX0, RX1, TX0, TX1) |
| sync_i | input | 4 | Frame sync per route, sampled with tick |
| sw_req_i | input | 4 | Half-switch request per route |
| bank_o | output | 4 | Active half per route |
| rx_pin_i | input | 2 | Receive pin level per link |
| rx_pin_o | output | 2 | Receive pin drive value per link |
| rx_pin_oe_o | output | 2 | Receive pin drive enable per link |
| tx_pin_i | input | 2 | Transmit pin level per link |
| tx_pin_o | output | 2 | Transmit pin drive value per link |
| tx_pin_oe_o | output | 2 | Transmit pin drive enable per link |
| tx_bit_i | input | 2 | Transmit data from channel per link |
| rx_bit_o | output | 2 | Received data to channel per link |
| rx_valid_o | output | 2 | Received bit valid per link |
| tx_take_o | output | 2 | Transmit bit consumed per link |
| chan_o | output | 12 | Current channel per route, 3 bits each |
| strb_o | output | 16 | Current strobes per route, 4 bits each |

## Verification
The bench replays frames from its own copy of the descriptors. It checks byte-granular runs, channel-0 gaps, a route that has all 16 entries and no last flag, and a second frame straight after the first. A sequencer that is off by one in its length count, or that runs past the last entry, puts the wrong channel on a bit. A frame that does not restart leaves the route idle. The swap flag is tested in both route kinds: a design that honours it in transmit descriptors moves the drive onto the receive pin. A half-switch request is checked across syncs of other routes and across plain ticks. Swapping early, or on a foreign sync, changes the active half and the channel before the expected frame.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int N_TDM  = 2;
  localparam int N_RT   = 2 * N_TDM;
  localparam int RT_W   = $clog2(N_RT);
  localparam int STRB_W = 4;
  localparam int CH_W   = 3;
  localparam int CNT_W  = 4;
  localparam int WORD_W = 16;
  localparam int RSVD_B = 9;

  typedef struct packed {
    logic              loop;
    logic              swap;
    logic [STRB_W-1:0] strb;
    logic [CH_W-1:0]   chan;
    logic [CNT_W-1:0]  cnt;
    logic              byte_g;
    logic              last;
  } slot_t;
endpackage

// File: rtl/tsa_route_mem.sv
module tsa_route_mem
  import tsa_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = 1 + RT_W + $clog2(N_ENT),
  localparam int DEPTH = 2 * N_RT * N_ENT
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [WORD_W-1:0]          wr_data_i,
  input  logic [N_RT-1:0][IDX_W-1:0] rd_idx_i,
  output slot_t [N_RT-1:0]           rd_ent_o
);
  slot_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= {wr_data_i[WORD_W-1:RSVD_B+1], wr_data_i[RSVD_B-1:0]};
    end
  end

  for (genvar r = 0; r < N_RT; r++) begin : g_rd
    assign rd_ent_o[r] = mem_q[rd_idx_i[r]];
  end

  AST_RSVD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !wr_data_i[RSVD_B]); // R2
endmodule

// File: rtl/tsa_seq.sv
module tsa_seq
  import tsa_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int PTR_W = $clog2(N_ENT),
  localparam int BC_W  = CNT_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             sync_i,
  input  logic             sw_req_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             byte_i,
  input  logic             last_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             run_o,
  output logic             bank_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [BC_W-1:0]  bcnt_q, len_m1;
  logic             run_q, bank_q, pend_q, done;

  assign len_m1 = byte_i ? {cnt_i, 3'b111} : {3'b000, cnt_i};
  assign done   = (bcnt_q == len_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      bcnt_q <= '0;
      run_q  <= 1'b0;
      bank_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (sw_req_i) pend_q <= 1'b1;
      if (tick_i) begin
        if (sync_i) begin
          run_q  <= 1'b1;
          ptr_q  <= '0;
          bcnt_q <= '0;
          if (pend_q || sw_req_i) begin
            bank_q <= ~bank_q;
            pend_q <= 1'b0;
          end
        end else if (run_q) begin
          if (done) begin
            bcnt_q <= '0;
            if (last_i || ptr_q == PTR_W'(N_ENT - 1)) run_q <= 1'b0;
            else ptr_q <= ptr_q + 1'b1;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign ptr_o  = ptr_q;
  assign run_o  = run_q;
  assign bank_o = bank_q;

  AST_SYNC_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && sync_i |=> run_q && ptr_q == '0 && bcnt_q == '0); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(ptr_q) && $stable(run_q) && $stable(bcnt_q)); // R4
  AST_STOP_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && tick_i && !sync_i && done && last_i |=> !run_q); // R5
  AST_BANK_AT_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && sync_i) |=> $stable(bank_q)); // R12
endmodule

// File: rtl/tsa_pin_mux.sv
module tsa_pin_mux
  import tsa_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rx_tick_i,
  input  logic            tx_tick_i,
  input  logic [CH_W-1:0] rx_chan_i,
  input  logic            rx_loop_i,
  input  logic            rx_swap_i,
  input  logic [CH_W-1:0] tx_chan_i,
  input  logic            tx_loop_i,
  input  logic            rx_pin_i,
  input  logic            tx_pin_i,
  input  logic            tx_bit_i,
  output logic            rx_pin_o,
  output logic            rx_pin_oe_o,
  output logic            tx_pin_o,
  output logic            tx_pin_oe_o,
  output logic            rx_bit_o,
  output logic            rx_valid_o,
  output logic            tx_take_o
);
  logic tx_drive;

  assign tx_drive    = (tx_chan_i != '0) && !tx_loop_i;
  assign tx_pin_o    = tx_bit_i;
  assign rx_pin_o    = tx_bit_i;
  assign tx_pin_oe_o = tx_drive && !rx_swap_i;
  assign rx_pin_oe_o = tx_drive && rx_swap_i;

  always_comb begin
    if (rx_loop_i)      rx_bit_o = tx_bit_i;
    else if (rx_swap_i) rx_bit_o = tx_pin_i;
    else                rx_bit_o = rx_pin_i;
  end

  assign rx_valid_o = rx_tick_i && (rx_chan_i != '0);
  assign tx_take_o  = tx_tick_i && (tx_chan_i != '0);

  AST_ONE_DRIVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_pin_oe_o && tx_pin_oe_o)); // R11
  AST_IDLE_SLOT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_chan_i == '0 |-> !tx_pin_oe_o && !rx_pin_oe_o && !tx_take_o); // R7
  AST_LOOP_OFF_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_loop_i |-> !tx_pin_oe_o && !rx_pin_oe_o); // R10
endmodule

// File: rtl/tdm_slot_assigner.sv
module tdm_slot_assigner
  import tsa_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int PTR_W = $clog2(N_ENT),
  localparam int IDX_W = 1 + RT_W + PTR_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [WORD_W-1:0]      wr_data_i,
  input  logic [N_RT-1:0]        tick_i,
  input  logic [N_RT-1:0]        sync_i,
  input  logic [N_RT-1:0]        sw_req_i,
  output logic [N_RT-1:0]        bank_o,
  input  logic [N_TDM-1:0]       rx_pin_i,
  output logic [N_TDM-1:0]       rx_pin_o,
  output logic [N_TDM-1:0]       rx_pin_oe_o,
  input  logic [N_TDM-1:0]       tx_pin_i,
  output logic [N_TDM-1:0]       tx_pin_o,
  output logic [N_TDM-1:0]       tx_pin_oe_o,
  input  logic [N_TDM-1:0]       tx_bit_i,
  output logic [N_TDM-1:0]       rx_bit_o,
  output logic [N_TDM-1:0]       rx_valid_o,
  output logic [N_TDM-1:0]       tx_take_o,
  output logic [N_RT*CH_W-1:0]   chan_o,
  output logic [N_RT*STRB_W-1:0] strb_o
);
  logic [N_RT-1:0][IDX_W-1:0] rd_idx;
  slot_t [N_RT-1:0]           rd_ent;
  logic [N_RT-1:0][PTR_W-1:0] ptr;
  logic [N_RT-1:0]            run;
  logic [N_RT-1:0][CH_W-1:0]  cur_chan;
  logic [N_RT-1:0]            cur_loop, cur_swap;

  tsa_route_mem #(.N_ENT(N_ENT)) u_mem (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_data_i,
    .rd_idx_i(rd_idx), .rd_ent_o(rd_ent)
  );

  for (genvar r = 0; r < N_RT; r++) begin : g_rt
    tsa_seq #(.N_ENT(N_ENT)) u_seq (
      .clk_i, .rst_ni,
      .tick_i(tick_i[r]), .sync_i(sync_i[r]), .sw_req_i(sw_req_i[r]),
      .cnt_i(rd_ent[r].cnt), .byte_i(rd_ent[r].byte_g), .last_i(rd_ent[r].last),
      .ptr_o(ptr[r]), .run_o(run[r]), .bank_o(bank_o[r])
    );
    assign rd_idx[r] = {bank_o[r], RT_W'(r), ptr[r]};
    assign cur_chan[r] = run[r] ? rd_ent[r].chan : '0;
    assign cur_loop[r] = run[r] & rd_ent[r].loop;
    assign cur_swap[r] = run[r] & rd_ent[r].swap;
    assign chan_o[r*CH_W +: CH_W]       = cur_chan[r];
    assign strb_o[r*STRB_W +: STRB_W]   = run[r] ? rd_ent[r].strb : '0;
  end

  for (genvar t = 0; t < N_TDM; t++) begin : g_tdm
    // swap flag taken from the receive route only
    tsa_pin_mux u_mux (
      .clk_i, .rst_ni,
      .rx_tick_i(tick_i[t]), .tx_tick_i(tick_i[N_TDM+t]),
      .rx_chan_i(cur_chan[t]), .rx_loop_i(cur_loop[t]), .rx_swap_i(cur_swap[t]),
      .tx_chan_i(cur_chan[N_TDM+t]), .tx_loop_i(cur_loop[N_TDM+t]),
      .rx_pin_i(rx_pin_i[t]), .tx_pin_i(tx_pin_i[t]), .tx_bit_i(tx_bit_i[t]),
      .rx_pin_o(rx_pin_o[t]), .rx_pin_oe_o(rx_pin_oe_o[t]),
      .tx_pin_o(tx_pin_o[t]), .tx_pin_oe_o(tx_pin_oe_o[t]),
      .rx_bit_o(rx_bit_o[t]), .rx_valid_o(rx_valid_o[t]), .tx_take_o(tx_take_o[t])
    );
  end

  // an unused transmit swap flag must not leak into the pin muxes
  AST_TX_SWAP_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cur_swap[0] && !cur_swap[1] |-> rx_pin_oe_o == '0); // R11
endmodule

// File: tb/tdm_slot_assigner_test.sv
`timescale 1ns/1ps
module tdm_slot_assigner_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [6:0] wr_idx = 0;
  logic [15:0] wr_data = 0;
  logic [3:0] tick = 0, sync = 0, sw_req = 0;
  logic [3:0] bank;
  logic [1:0] rx_pin = 0, tx_pin = 0, tx_bit = 0;
  logic [1:0] rx_pin_o, rx_pin_oe, tx_pin_o, tx_pin_oe, rx_bit, rx_valid, tx_take;
  logic [11:0] chan;
  logic [15:0] strb;

  int n_chk = 0, n_err = 0;
  logic [15:0] bmem [128];
  logic [3:0] bank_m = 0;
  int exp_ch [2048];
  int exp_st [2048];

  always #10 clk = ~clk;

  tdm_slot_assigner uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .tick_i(tick), .sync_i(sync), .sw_req_i(sw_req), .bank_o(bank),
    .rx_pin_i(rx_pin), .rx_pin_o(rx_pin_o), .rx_pin_oe_o(rx_pin_oe),
    .tx_pin_i(tx_pin), .tx_pin_o(tx_pin_o), .tx_pin_oe_o(tx_pin_oe),
    .tx_bit_i(tx_bit), .rx_bit_o(rx_bit), .rx_valid_o(rx_valid), .tx_take_o(tx_take),
    .chan_o(chan), .strb_o(strb)
  );

  function automatic logic [15:0] mk(bit lp, bit sw, int st, int ch, int cn, bit by, bit ls);
    return {lp, sw, 4'(st), 1'b0, 3'(ch), 4'(cn), by, ls};
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int half, int rt, int ent, logic [15:0] d);
    int idx = half * 64 + rt * 16 + ent;
    @(negedge clk);
    wr_en = 1; wr_idx = 7'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    bmem[idx] = d;
  endtask

  task automatic clear_route(int rt);
    for (int k = 0; k < 16; k++) wr(bank_m[rt], rt, k, 16'h0);
  endtask

  task automatic tick_on(logic [3:0] t, logic [3:0] s);
    @(negedge clk);
    tick = t; sync = s;
    #1;
  endtask

  task automatic tick_off;
    @(posedge clk);
    #1;
    tick = 0; sync = 0;
  endtask

  // expand the active route from the bench copy and walk one frame
  task automatic run_frame(int rt, string tag);
    int n = 0;
    for (int p = 0; p < 16; p++) begin
      logic [15:0] w = bmem[bank_m[rt] * 64 + rt * 16 + p];
      int len = w[1] ? (int'(w[5:2]) + 1) * 8 : int'(w[5:2]) + 1;
      for (int b = 0; b < len; b++) begin
        exp_ch[n] = int'(w[8:6]);
        exp_st[n] = int'(w[13:10]);
        n++;
      end
      if (w[0]) break;
    end
    tick_on(4'(1 << rt), 4'(1 << rt)); tick_off;
    for (int i = 0; i < n; i++) begin
      tick_on(4'(1 << rt), 4'h0);
      check({tag, " R4"}, $sformatf("chan bit %0d", i), int'(chan[rt*3 +: 3]), exp_ch[i]);
      check({tag, " R6"}, $sformatf("strb bit %0d", i), int'(strb[rt*4 +: 4]), exp_st[i]);
      tick_off;
    end
    tick_on(4'(1 << rt), 4'h0);
    check("R5", "idle chan", int'(chan[rt*3 +: 3]), 0);
    check("R5", "idle strb", int'(strb[rt*4 +: 4]), 0);
    tick_off;
  endtask

  task automatic t_reset;
    check("R1", "bank", int'(bank), 0);
    check("R1", "chan", int'(chan), 0);
    check("R1", "strb", int'(strb), 0);
    check("R1", "pin oe", int'({rx_pin_oe, tx_pin_oe}), 0);
    check("R1", "valid/take", int'({rx_valid, tx_take}), 0);
  endtask

  task automatic t_frame_rx0;
    wr(0, 0, 0, mk(0, 0, 1, 1, 2, 0, 0));
    wr(0, 0, 1, mk(0, 0, 0, 0, 0, 0, 0));
    wr(0, 0, 2, mk(0, 0, 4, 2, 0, 1, 0));   // byte run of 8 bits
    wr(0, 0, 3, mk(0, 0, 8, 3, 1, 0, 1));   // last
    wr(0, 0, 4, mk(0, 0, 2, 7, 0, 0, 1));   // must never show
    run_frame(0, "R3");
    run_frame(0, "R3 second frame");
  endtask

  task automatic t_no_last;
    for (int k = 0; k < 16; k++) wr(0, 3, k, mk(0, 0, k, (k % 7) + 1, k % 3, 0, 0));
    run_frame(3, "R5 full list");
  endtask

  task automatic t_rx_data;
    logic [3:0] pat = 4'b1101;
    clear_route(1);
    wr(0, 1, 0, mk(0, 0, 0, 0, 1, 0, 0));
    wr(0, 1, 1, mk(0, 0, 0, 4, 3, 0, 1));
    tick_on(4'b0010, 4'b0010); tick_off;
    for (int i = 0; i < 2; i++) begin
      tick_on(4'b0010, 4'h0);
      check("R7", "rx valid in ch0 slot", int'(rx_valid[1]), 0);
      tick_off;
    end
    for (int i = 0; i < 4; i++) begin
      rx_pin[1] = pat[i];
      tick_on(4'b0010, 4'h0);
      check("R8", "rx valid", int'(rx_valid[1]), 1);
      check("R8", "rx bit", int'(rx_bit[1]), int'(pat[i]));
      check("R8", "chan", int'(chan[5:3]), 4);
      tick_off;
    end
    tick_on(4'b0010, 4'h0);
    check("R5", "rx valid after last", int'(rx_valid[1]), 0);
    tick_off;
  endtask

  task automatic t_tx;
    clear_route(2);
    wr(0, 2, 0, mk(0, 1, 0, 3, 1, 0, 0));   // swap flag set in a transmit entry
    wr(0, 2, 1, mk(0, 0, 0, 0, 0, 0, 1));
    tick_on(4'b0100, 4'b0100); tick_off;
    for (int i = 0; i < 2; i++) begin
      tx_bit[0] = 1'(i);
      tick_on(4'b0100, 4'h0);
      check("R9", "tx oe", int'(tx_pin_oe[0]), 1);
      check("R9", "tx pin", int'(tx_pin_o[0]), i);
      check("R9", "tx take", int'(tx_take[0]), 1);
      check("R11", "tx-entry swap ignored, rx oe", int'(rx_pin_oe[0]), 0);
      tick_off;
    end
    tick_on(4'b0100, 4'h0);
    check("R7", "tx oe ch0", int'(tx_pin_oe[0]), 0);
    check("R7", "tx take ch0", int'(tx_take[0]), 0);
    tick_off;
  endtask

  task automatic t_loop;
    clear_route(0); clear_route(2);
    wr(0, 0, 0, mk(1, 0, 0, 1, 3, 0, 1));
    wr(0, 2, 0, mk(1, 0, 0, 2, 3, 0, 1));
    tick_on(4'b0101, 4'b0101); tick_off;
    for (int i = 0; i < 4; i++) begin
      tx_bit[0] = 1'(i >> 1);
      rx_pin[0] = ~tx_bit[0];
      tick_on(4'b0101, 4'h0);
      check("R10", "rx bit looped", int'(rx_bit[0]), int'(tx_bit[0]));
      check("R10", "tx oe off", int'(tx_pin_oe[0]), 0);
      check("R10", "rx oe off", int'(rx_pin_oe[0]), 0);
      tick_off;
    end
  endtask

  task automatic t_swap;
    clear_route(0); clear_route(2);
    wr(0, 0, 0, mk(0, 1, 0, 1, 3, 0, 1));
    wr(0, 2, 0, mk(0, 0, 0, 2, 3, 0, 1));
    tick_on(4'b0101, 4'b0101); tick_off;
    for (int i = 0; i < 4; i++) begin
      tx_pin[0] = 1'(i & 1);
      rx_pin[0] = ~tx_pin[0];
      tx_bit[0] = 1'(i >> 1);
      tick_on(4'b0101, 4'h0);
      check("R11", "rx from tx pin", int'(rx_bit[0]), int'(tx_pin[0]));
      check("R11", "data on rx pin", int'(rx_pin_o[0]), int'(tx_bit[0]));
      check("R11", "rx pin oe", int'(rx_pin_oe[0]), 1);
      check("R11", "tx pin oe", int'(tx_pin_oe[0]), 0);
      tick_off;
    end
  endtask

  task automatic t_bank;
    clear_route(1);
    wr(0, 1, 0, mk(0, 0, 0, 4, 0, 0, 1));
    wr(1, 1, 0, mk(0, 0, 0, 5, 0, 0, 1));   // R2 shadow index 80
    @(negedge clk); sw_req = 4'b0010;
    @(negedge clk); sw_req = 0;
    check("R12", "bank held", int'(bank[1]), 0);
    tick_on(4'b0001, 4'b0001); tick_off;    // other route's sync
    check("R12", "foreign sync", int'(bank[1]), 0);
    tick_on(4'b0010, 4'h0); tick_off;
    check("R12", "plain tick", int'(bank[1]), 0);
    tick_on(4'b0010, 4'b0010); tick_off;
    check("R12", "switched", int'(bank[1]), 1);
    tick_on(4'b0010, 4'h0);
    check("R12", "shadow chan", int'(chan[5:3]), 5);
    tick_off;
    @(negedge clk); sw_req = 4'b0010;
    @(negedge clk); sw_req = 0;
    tick_on(4'b0010, 4'b0010); tick_off;
    check("R12", "switched back", int'(bank[1]), 0);
    tick_on(4'b0010, 4'h0);
    check("R12", "active chan", int'(chan[5:3]), 4);
    tick_off;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) bmem[i] = 16'h0;
    repeat (3) @(negedge clk);
    #1;
    t_reset;
    rst_n = 1;
    t_frame_rx0;
    t_no_last;
    t_rx_data;
    t_tx;
    t_loop;
    t_swap;
    t_bank;
    repeat (2) @(negedge clk);
    finish_run;
  end

  initial begin
    #4_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run;
  end
endmodule